// File: doc/BRIEF.md
# Dual-Channel Alternating-Phase Pulse Generator

The block holds two programmable pulse channels, C and D. Each channel has an 8-bit down counter and two reload values, one for the low phase and one for the high phase. Each time the counter underflows, it reloads from the value for the other phase and the channel's output latch inverts. The low and high widths of the waveform are therefore set independently. Counting runs on a tick picked per channel: a divided copy of the machine-clock enable, or an external timebase tick.

A mode field in channel D's control register sets how the channels relate. They can run side by side as two 8-bit generators. Channel D can count channel C's underflows. Or the two counters can join into one 16-bit generator: channel D holds the upper byte, channel C holds the lower byte, and the waveform appears on pin D. Software reaches the block through a small write/read register bus. The underflow flags of the two channels, each gated by its own interrupt enable, are combined into one interrupt line.

Top module: `ppgPair`

## Requirements
- R1: After reset, both pins and the interrupt are low, and all seven registers read 0.
- R2: Register map:
  - Address 0 is control C and address 1 is control D: bit 0 run, bit 1 output enable, bit 2 interrupt enable, bit 3 underflow flag.
  - Addresses 3 and 4 are C's low and high reload values; addresses 5 and 6 are D's low and high reload values.
  - An underflow is a count tick that arrives while the counter is 0.
  - A low reload L gives a low phase of L+1 ticks. A high reload H gives a high phase of H+1 ticks.
  - The output latch is 1 exactly during the high phase, and the two phases alternate.
- R3: Address 2 holds C's clock select in bits [2:0] and D's in bits [6:4]. Codes 0 to 4 tick once every 2^code cycles in which clkEn is high. Code 5 ticks on tbTick. Codes 6 and 7 give no ticks.
- R4: While the run bit is 0, the latch is low and the counter holds the low reload value. After run is set, the first phase is low and lasts L+1 ticks.
- R5: With the output enable bit at 0, the pin stays low while counting and underflow flags continue. With it at 1, the pin follows the latch.
- R6: An underflow sets the channel's flag. Writing 0 to the flag bit clears it, and writing 1 leaves it unchanged.
- R7: irq is high when channel C's flag and interrupt enable are both set, or when channel D's flag and interrupt enable are both set.
- R8: A write to a high-reload address (4 or 6) goes into a holding buffer. Reading that address still returns the previous value. The next write to the same channel's low-reload address (3 or 5) commits the low value and the buffered high value on the same edge.
- R9: Control D bits [5:4] select the mode. 00 and 11 mean independent channels. 01 means channel D counts channel C's underflows in place of its own clock select.
- R10: Mode 10 forms one 16-bit generator:
  - The reload pairs are {D low, C low} and {D high, C high}, giving phases of N+1 ticks.
  - The count tick is C's clock select, and the run bit is D's.
  - The waveform is on pin D, and D's flag is set on underflow.
  - Pin C stays low, and C's flag is not set.
- R11: In independent mode, the two channels run at the same time with different reload values and clock selects without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Machine-clock enable that feeds the prescaler |
| tbTick | input | 1 | External timebase tick, one cycle wide |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for addr, combinational |
| pinC | output | 1 | Channel C pulse output |
| pinD | output | 1 | Channel D pulse output, also the 16-bit output |
| irq | output | 1 | Combined interrupt request |

## Verification
The phase widths are tried with several pairs of reload values: equal zero values, a short low phase against a long high phase, and the reverse. Swapping the two widths would show up as a mismatch. Each prescaler tap, the timebase tick and a disabled code are used with the same reload pair, so a wrong tap or a wrong select decode gives a width that differs by a known factor. The chained and 16-bit modes use reload pairs whose widths differ from the independent-mode widths. A wrong byte order or a missing borrow in the 16-bit mode therefore gives a clearly different low width (258 expected). A buffered high write that is read back and measured before and after its commit separates an immediate update from a deferred one.

// File: rtl/ppgPairPkg.sv
`timescale 1ns/1ps
package ppgPairPkg;

  typedef enum logic [1:0] {
    MODE_SPLIT     = 2'b00,
    MODE_CHAIN     = 2'b01,
    MODE_WIDE      = 2'b10,
    MODE_SPLIT_ALT = 2'b11
  } cascadeMode_t;

  typedef struct packed {
    logic runC;
    logic runD;
    logic tickC;
    logic tickD;
    logic chain;
    logic wide;
  } ppgStrobes_t;

  localparam int ADR_CTL_C = 0;
  localparam int ADR_CTL_D = 1;
  localparam int ADR_CLK   = 2;
  localparam int ADR_C_LO  = 3;
  localparam int ADR_C_HI  = 4;
  localparam int ADR_D_LO  = 5;
  localparam int ADR_D_HI  = 6;

  localparam int BIT_RUN  = 0;
  localparam int BIT_OE   = 1;
  localparam int BIT_IE   = 2;
  localparam int BIT_FLAG = 3;

endpackage

// File: rtl/ppgPairCtrl.sv
`timescale 1ns/1ps
module ppgPairCtrl
  import ppgPairPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_TAPS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              tbTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  input  logic              uflowC,
  input  logic              uflowD,
  output ppgStrobes_t       strobes,
  output logic [CNT_W-1:0]  loC,
  output logic [CNT_W-1:0]  hiC,
  output logic [CNT_W-1:0]  loD,
  output logic [CNT_W-1:0]  hiD,
  output logic              oeC,
  output logic              oeD,
  output logic              irq
);

  localparam int SEL_W   = $clog2(NUM_TAPS + 2);
  localparam int PRE_W   = NUM_TAPS - 1;
  localparam int TB_CODE = NUM_TAPS;

  logic runC, ieC, flagC;
  logic runD, ieD, flagD;
  cascadeMode_t mode;
  logic [SEL_W-1:0] selC, selD;
  logic [CNT_W-1:0] bufC, bufD;
  logic [PRE_W-1:0] preCnt;
  logic [NUM_TAPS-1:0] tapTick;
  logic tickSelC, tickSelD;

  logic wrCtlC, wrCtlD, wrClk, wrCLo, wrCHi, wrDLo, wrDHi;
  assign wrCtlC = wrEn && (addr == ADDR_W'(ADR_CTL_C));
  assign wrCtlD = wrEn && (addr == ADDR_W'(ADR_CTL_D));
  assign wrClk  = wrEn && (addr == ADDR_W'(ADR_CLK));
  assign wrCLo  = wrEn && (addr == ADDR_W'(ADR_C_LO));
  assign wrCHi  = wrEn && (addr == ADDR_W'(ADR_C_HI));
  assign wrDLo  = wrEn && (addr == ADDR_W'(ADR_D_LO));
  assign wrDHi  = wrEn && (addr == ADDR_W'(ADR_D_HI));

  // Free-running prescaler shared by both channels
  always_ff @(posedge clk) begin
    if (!rstN)      preCnt <= '0;
    else if (clkEn) preCnt <= preCnt + 1'b1;
  end

  assign tapTick[0] = clkEn;
  for (genvar g = 1; g < NUM_TAPS; g++) begin : gTap
    assign tapTick[g] = clkEn && (&preCnt[g-1:0]);
  end

  function automatic logic pickTick(input logic [SEL_W-1:0] sel,
                                    input logic [NUM_TAPS-1:0] taps,
                                    input logic tb);
    logic t;
    t = 1'b0;
    for (int i = 0; i < NUM_TAPS; i++)
      if (sel == SEL_W'(i)) t = taps[i];
    if (sel == SEL_W'(TB_CODE)) t = tb;
    return t;
  endfunction

  assign tickSelC = pickTick(selC, tapTick, tbTick);
  assign tickSelD = pickTick(selD, tapTick, tbTick);

  // Control registers and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      runC <= 1'b0; oeC <= 1'b0; ieC <= 1'b0; flagC <= 1'b0;
      runD <= 1'b0; oeD <= 1'b0; ieD <= 1'b0; flagD <= 1'b0;
      mode <= MODE_SPLIT;
      selC <= '0; selD <= '0;
    end else begin
      if (wrCtlC) begin
        runC <= wrData[BIT_RUN];
        oeC  <= wrData[BIT_OE];
        ieC  <= wrData[BIT_IE];
      end
      if (wrCtlD) begin
        runD <= wrData[BIT_RUN];
        oeD  <= wrData[BIT_OE];
        ieD  <= wrData[BIT_IE];
        mode <= cascadeMode_t'(wrData[5:4]);
      end
      if (uflowC)                           flagC <= 1'b1;
      else if (wrCtlC && !wrData[BIT_FLAG]) flagC <= 1'b0;
      if (uflowD)                           flagD <= 1'b1;
      else if (wrCtlD && !wrData[BIT_FLAG]) flagD <= 1'b0;
      if (wrClk) begin
        selC <= wrData[SEL_W-1:0];
        selD <= wrData[4 +: SEL_W];
      end
    end
  end

  // Reload pairs: high side buffered until the low side is written
  always_ff @(posedge clk) begin
    if (!rstN) begin
      loC <= '0; hiC <= '0; bufC <= '0;
      loD <= '0; hiD <= '0; bufD <= '0;
    end else begin
      if (wrCHi) bufC <= wrData;
      if (wrCLo) begin
        loC <= wrData;
        hiC <= bufC;
      end
      if (wrDHi) bufD <= wrData;
      if (wrDLo) begin
        loD <= wrData;
        hiD <= bufD;
      end
    end
  end

  always_comb begin
    strobes.wide  = (mode == MODE_WIDE);
    strobes.chain = (mode == MODE_CHAIN);
    strobes.runD  = runD;
    strobes.runC  = strobes.wide ? runD : runC;
    strobes.tickC = tickSelC;
    strobes.tickD = tickSelD;
  end

  assign irq = (flagC && ieC) || (flagD && ieD);

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(ADR_CTL_C): rdData = CNT_W'({flagC, ieC, oeC, runC});
      ADDR_W'(ADR_CTL_D): rdData = CNT_W'({mode, flagD, ieD, oeD, runD});
      ADDR_W'(ADR_CLK): begin
        rdData[SEL_W-1:0] = selC;
        rdData[4 +: SEL_W] = selD;
      end
      ADDR_W'(ADR_C_LO):  rdData = loC;
      ADDR_W'(ADR_C_HI):  rdData = hiC;
      ADDR_W'(ADR_D_LO):  rdData = loD;
      ADDR_W'(ADR_D_HI):  rdData = hiD;
      default:            rdData = '0;
    endcase
  end

  AST_FLAG_SET_ON_UFLOW: assert property (@(posedge clk) disable iff (!rstN)
    uflowC |=> flagC); // R6
  AST_FLAG_D_SET_ON_UFLOW: assert property (@(posedge clk) disable iff (!rstN)
    uflowD |=> flagD); // R6
  AST_FLAG_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtlC && wrData[BIT_FLAG] && flagC) |=> flagC); // R6
  AST_HI_BUFFERED: assert property (@(posedge clk) disable iff (!rstN)
    wrCHi |=> $stable(hiC)); // R8
  AST_HI_D_BUFFERED: assert property (@(posedge clk) disable iff (!rstN)
    wrDHi |=> $stable(hiD)); // R8

endmodule

// File: rtl/ppgPairDatapath.sv
`timescale 1ns/1ps
module ppgPairDatapath
  import ppgPairPkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ppgStrobes_t      strobes,
  input  logic [CNT_W-1:0] loC,
  input  logic [CNT_W-1:0] hiC,
  input  logic [CNT_W-1:0] loD,
  input  logic [CNT_W-1:0] hiD,
  output logic             uflowC,
  output logic             uflowD,
  output logic             latchC,
  output logic             latchD
);

  logic [CNT_W-1:0] cntC, cntD;
  logic cZero, dZero, wideStep, tickDEff;

  always_comb begin
    cZero    = (cntC == '0);
    dZero    = (cntD == '0);
    uflowC   = !strobes.wide && strobes.runC && strobes.tickC && cZero;
    wideStep = strobes.wide && strobes.runD && strobes.tickC && cZero;
    tickDEff = strobes.chain ? uflowC : strobes.tickD;
    uflowD   = strobes.wide ? (wideStep && dZero)
                            : (strobes.runD && tickDEff && dZero);
  end

  // Channel C: independent counter, or low byte in wide mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntC <= '0;
      latchC <= 1'b0;
    end else if (!strobes.runC) begin
      cntC <= loC;
      latchC <= 1'b0;
    end else if (strobes.wide) begin
      latchC <= 1'b0;
      if (strobes.tickC) begin
        if (!cZero)     cntC <= cntC - 1'b1;
        else if (dZero) cntC <= latchD ? loC : hiC;
        else            cntC <= '1;
      end
    end else if (strobes.tickC) begin
      if (cZero) begin
        cntC <= latchC ? loC : hiC;
        latchC <= ~latchC;
      end else begin
        cntC <= cntC - 1'b1;
      end
    end
  end

  // Channel D: independent, chained to C underflow, or high byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntD <= '0;
      latchD <= 1'b0;
    end else if (!strobes.runD) begin
      cntD <= loD;
      latchD <= 1'b0;
    end else if (strobes.wide) begin
      if (strobes.tickC && cZero) begin
        if (dZero) begin
          cntD <= latchD ? loD : hiD;
          latchD <= ~latchD;
        end else begin
          cntD <= cntD - 1'b1;
        end
      end
    end else if (tickDEff) begin
      if (dZero) begin
        cntD <= latchD ? loD : hiD;
        latchD <= ~latchD;
      end else begin
        cntD <= cntD - 1'b1;
      end
    end
  end

  AST_STOP_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runC |=> !latchC); // R4
  AST_STOP_CLEARS_LATCH_D: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.runD |=> !latchD); // R4
  AST_UFLOW_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    uflowC |=> (latchC != $past(latchC))); // R2
  AST_UFLOW_D_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    uflowD |=> (latchD != $past(latchD))); // R2
  AST_HOLD_WITHOUT_UFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.runC && !strobes.wide && !uflowC) |=> $stable(latchC)); // R2
  AST_WIDE_C_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wide |=> !latchC); // R10

endmodule

// File: rtl/ppgPair.sv
`timescale 1ns/1ps
module ppgPair
  import ppgPairPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int ADDR_W   = 3,
  parameter int NUM_TAPS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              tbTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              pinC,
  output logic              pinD,
  output logic              irq
);

  ppgStrobes_t strobes;
  logic [CNT_W-1:0] loC, hiC, loD, hiD;
  logic uflowC, uflowD, latchC, latchD, oeC, oeD;

  ppgPairCtrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .NUM_TAPS(NUM_TAPS)) uCtrl (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .tbTick(tbTick),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .uflowC(uflowC), .uflowD(uflowD), .strobes(strobes),
    .loC(loC), .hiC(hiC), .loD(loD), .hiD(hiD),
    .oeC(oeC), .oeD(oeD), .irq(irq)
  );

  ppgPairDatapath #(.CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .loC(loC), .hiC(hiC), .loD(loD), .hiD(hiD),
    .uflowC(uflowC), .uflowD(uflowD), .latchC(latchC), .latchD(latchD)
  );

  assign pinC = latchC && oeC;
  assign pinD = latchD && oeD;

endmodule

// File: tb/ppgPair_test.sv
`timescale 1ns/1ps
module ppgPair_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clkEn = 1'b1;
  logic tbTick = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic pinC, pinD, irq;

  int tests = 0;
  int fails = 0;
  bit tbOn = 1'b0;
  int tbCnt = 0;

  ppgPair uut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .tbTick(tbTick),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .pinC(pinC), .pinD(pinD), .irq(irq)
  );

  always #5 clk = ~clk;

  // timebase tick: one cycle in every 20 while enabled
  initial begin
    forever begin
      @(negedge clk);
      if (tbOn) begin
        tbCnt++;
        tbTick = (tbCnt % 20 == 0);
      end else begin
        tbTick = 1'b0;
        tbCnt = 0;
      end
    end
  end

  initial begin
    #1500000;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    fails++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; wrEn = 1'b0; addr = '0; wrData = '0; clkEn = 1'b1; tbOn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeReg(input int a, input int d);
    addr = 3'(a); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input int a, output int d);
    addr = 3'(a);
    #1;
    d = int'(rdData);
  endtask

  function automatic logic curPin(input bit chD);
    return chD ? pinD : pinC;
  endfunction

  task automatic measure(input bit chD, output int hiLen, output int loLen);
    int guard = 0;
    while (curPin(chD) && guard < 4000) begin @(negedge clk); guard++; end
    while (!curPin(chD) && guard < 4000) begin @(negedge clk); guard++; end
    hiLen = 0;
    while (curPin(chD) && guard < 4000) begin hiLen++; @(negedge clk); guard++; end
    loLen = 0;
    while (!curPin(chD) && guard < 4000) begin loLen++; @(negedge clk); guard++; end
    if (guard >= 4000) begin hiLen = -1; loLen = -1; end
  endtask

  task automatic testReset();
    int v;
    doReset();
    for (int a = 0; a < 7; a++) begin
      readReg(a, v);
      chk("R1 register reads zero", v, 0);
    end
    chk("R1 pinC low", int'(pinC), 0);
    chk("R1 pinD low", int'(pinD), 0);
    chk("R1 irq low", int'(irq), 0);
  endtask

  task automatic testPhases();
    int los[3] = '{3, 0, 7};
    int his[3] = '{5, 0, 1};
    int h, l, v;
    for (int i = 0; i < 3; i++) begin
      doReset();
      writeReg(2, 0);
      writeReg(4, his[i]);
      writeReg(3, los[i]);
      writeReg(0, 8'h0B);
      readReg(4, v);
      chk("R2 high reload read back", v, his[i]);
      measure(1'b0, h, l);
      chk("R2 high phase width", h, his[i] + 1);
      chk("R2 low phase width", l, los[i] + 1);
    end
  endtask

  task automatic testDivide();
    int h, l, cnt;
    for (int c = 1; c <= 5; c++) begin
      doReset();
      if (c == 5) tbOn = 1'b1;
      writeReg(2, c);
      writeReg(4, 2);
      writeReg(3, 1);
      writeReg(0, 8'h0B);
      measure(1'b0, h, l);
      chk("R3 divided high width", h, (c == 5) ? 60 : 3 * (1 << c));
      chk("R3 divided low width", l, (c == 5) ? 40 : 2 * (1 << c));
    end
    doReset();
    writeReg(2, 6);
    writeReg(4, 0);
    writeReg(3, 0);
    writeReg(0, 8'h0B);
    cnt = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (pinC) cnt++;
    end
    chk("R3 code 6 gives no ticks", cnt, 0);
  endtask

  task automatic testStopRestart();
    int h, l, cnt, guard;
    doReset();
    writeReg(2, 0);
    writeReg(4, 2);
    writeReg(3, 4);
    writeReg(0, 8'h0B);
    measure(1'b0, h, l);
    guard = 0;
    while (!pinC && guard < 100) begin @(negedge clk); guard++; end
    writeReg(0, 8'h0A);
    @(negedge clk);
    chk("R4 stop drives pin low", int'(pinC), 0);
    cnt = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (pinC) cnt++;
    end
    chk("R4 stays low while stopped", cnt, 0);
    writeReg(0, 8'h0B);
    cnt = 0;
    guard = 0;
    while (!pinC && guard < 100) begin cnt++; @(negedge clk); guard++; end
    chk("R4 first phase after restart is low L+1", cnt, 5);
  endtask

  task automatic testOutEnable();
    int h, l, cnt, v;
    doReset();
    writeReg(2, 0);
    writeReg(4, 1);
    writeReg(3, 1);
    writeReg(0, 8'h09);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pinC) cnt++;
    end
    chk("R5 pin held low when output disabled", cnt, 0);
    readReg(0, v);
    chk("R5 counting continues (flag set)", (v >> 3) & 1, 1);
    writeReg(0, 8'h0B);
    measure(1'b0, h, l);
    chk("R5 high width after enable", h, 2);
    chk("R5 low width after enable", l, 2);
  endtask

  task automatic testFlagIrq();
    int v;
    doReset();
    writeReg(2, 0);
    writeReg(4, 1);
    writeReg(3, 1);
    writeReg(0, 8'h09);
    repeat (10) @(negedge clk);
    writeReg(0, 8'h08);
    readReg(0, v);
    chk("R6 flag set by underflow", (v >> 3) & 1, 1);
    chk("R7 irq low with enable off", int'(irq), 0);
    writeReg(0, 8'h0C);
    readReg(0, v);
    chk("R6 writing 1 keeps flag", (v >> 3) & 1, 1);
    chk("R7 irq from channel C", int'(irq), 1);
    writeReg(0, 8'h04);
    readReg(0, v);
    chk("R6 writing 0 clears flag", (v >> 3) & 1, 0);
    chk("R7 irq drops after clear", int'(irq), 0);
    writeReg(6, 1);
    writeReg(5, 1);
    writeReg(1, 8'h0D);
    repeat (10) @(negedge clk);
    chk("R7 irq from channel D alone", int'(irq), 1);
  endtask

  task automatic testBuffer();
    int h, l, v;
    doReset();
    writeReg(2, 0);
    writeReg(4, 5);
    writeReg(3, 3);
    writeReg(0, 8'h0B);
    writeReg(4, 9);
    readReg(4, v);
    chk("R8 high read unchanged before commit", v, 5);
    measure(1'b0, h, l);
    chk("R8 high width unchanged before commit", h, 6);
    writeReg(3, 3);
    readReg(4, v);
    chk("R8 high committed by low write", v, 9);
    measure(1'b0, h, l);
    chk("R8 high width after commit", h, 10);
    chk("R8 low width after commit", l, 4);
  endtask

  task automatic testChain();
    int h, l;
    doReset();
    writeReg(2, 8'h70);
    writeReg(4, 0);
    writeReg(3, 0);
    writeReg(6, 2);
    writeReg(5, 1);
    writeReg(0, 8'h09);
    writeReg(1, 8'h1B);
    measure(1'b1, h, l);
    chk("R9 chained D high width", h, 3);
    chk("R9 chained D low width", l, 2);
  endtask

  task automatic testWide();
    int h, l, v, cnt;
    doReset();
    writeReg(2, 0);
    writeReg(4, 5);
    writeReg(3, 1);
    writeReg(6, 0);
    writeReg(5, 1);
    writeReg(0, 8'h02);
    writeReg(1, 8'h2B);
    cnt = 0;
    measure(1'b1, h, l);
    chk("R10 wide high width", h, 6);
    chk("R10 wide low width", l, 258);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (pinC) cnt++;
    end
    chk("R10 pin C low in wide mode", cnt, 0);
    readReg(0, v);
    chk("R10 C flag not set", (v >> 3) & 1, 0);
    readReg(1, v);
    chk("R10 D flag set", (v >> 3) & 1, 1);
  endtask

  task automatic testIndependent();
    int h, l;
    doReset();
    writeReg(2, 8'h10);
    writeReg(4, 4);
    writeReg(3, 2);
    writeReg(6, 0);
    writeReg(5, 1);
    writeReg(0, 8'h0B);
    writeReg(1, 8'h0B);
    measure(1'b0, h, l);
    chk("R11 C high width", h, 5);
    chk("R11 C low width", l, 3);
    measure(1'b1, h, l);
    chk("R11 D high width", h, 2);
    chk("R11 D low width", l, 4);
  endtask

  initial begin
    testReset();
    testPhases();
    testDivide();
    testStopRestart();
    testOutEnable();
    testFlagIrq();
    testBuffer();
    testChain();
    testWide();
    testIndependent();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule